// File: doc/BRIEF.md
# Interval Timer with One-Shot and Periodic Modes

This block is a down-counting interval timer advanced by a one-microsecond tick-enable. Software writes one control word that holds the enable flag, the periodic flag and the interval length minus one. When the count has reached zero and one more tick arrives, the timer expires and raises a pending flag. That flag drives an active-high level interrupt, which stays set until software writes a one to the clear bit of the status word.

In one-shot mode the timer drops its own enable at expiry and goes idle. In periodic mode it reloads the programmed value and keeps counting, so a load of N-1 gives an expiry every N ticks. A periodic rate of R per second is therefore programmed as 0xC0000000 | (1000000/R - 1). Writing zero to the control word stops the timer.

Several copies can share one register block at offsets 0x00, 0x08, 0x50 and 0x58. The parameter `BASE_ADDR` sets which offset a given copy answers to. The control word sits at `BASE_ADDR` and the status word at `BASE_ADDR+4`.

The controller has three states:
- `ST_IDLE`: stopped.
- `ST_RUN_ONCE`: counting in one-shot mode.
- `ST_RUN_LOOP`: counting in periodic mode.

The transitions are:
- load_once: a control write with enable=1 and periodic=0, from any state to `ST_RUN_ONCE`.
- load_loop: a control write with enable=1 and periodic=1, from any state to `ST_RUN_LOOP`.
- stop: a control write with enable=0, from any state to `ST_IDLE`.
- once_expire: `ST_RUN_ONCE` to `ST_IDLE` at expiry.
- loop_expire: `ST_RUN_LOOP` back to `ST_RUN_LOOP` at expiry, reloading the count.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset, `irq` is 0, and reads of both the control word and the status word return 0.
- R2: A control write stores bit 31 as enable, bit 30 as periodic and bits [28:0] as the reload value, and also loads the count with that value. Reading the control word returns {enable, periodic, 0, reload} in bits 31, 30, 29 and [28:0].
- R3: While the timer is running, the count drops by one on each cycle with `tick` high and holds otherwise. The status word shows the live count in bits [28:0] and the pending flag in bit 30.
- R4: With the value N-1 loaded, `irq` rises after the Nth tick. A loaded 0 expires on the first tick, and the full 29-bit value 0x1FFFFFFF is accepted.
- R5: In one-shot mode, expiry clears the stored enable bit (control bit 31 reads 0). The count then stays at 0 and no further expiry occurs.
- R6: In periodic mode, expiry reloads the count from the reload value and the enable bit stays set.
- R7: `irq` stays high until a status write with bit 30 set. A status write with bit 30 clear leaves `irq` unchanged.
- R8: If an expiry and a clearing status write fall in the same cycle, the interrupt stays pending.
- R9: A control write of 0 stops counting and sets the count to 0, so later ticks cause no expiry. It does not clear a pending interrupt.
- R10: Writes to any address other than `BASE_ADDR` and `BASE_ADDR+4` change nothing, and reads of such addresses return 0.
- R11: A control write in the same cycle as a tick loads the new value, and that tick is not applied to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-microsecond tick-enable, one cycle wide |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is 0 when low |
| addr | input | ADDR_W (8) | Byte address within the register block |
| wdata | input | CNT_W+3 (32) | Write data |
| rdata | output | CNT_W+3 (32) | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt, active-high level |

## Verification
A wrong state in the controller shows at the ports within one tick. A timer that wrongly stays in `ST_RUN_ONCE` keeps decrementing from its old value. A timer that drops out of `ST_RUN_LOOP` shows a cleared enable bit in the control readback, and that shows on the very next read. A wrong count shows on the next status read, and it shifts the time at which `irq` rises by one or more ticks. The bench reads the status word at many points of each interval to catch these errors. A lost or stuck pending flag shows on `irq` in the cycle after the expiry or the clear write, and the same-cycle expiry and clear case is checked on purpose.

// File: rtl/tit_pkg.sv
`timescale 1ns/1ps
package tit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN_ONCE = 2'd1,
        ST_RUN_LOOP = 2'd2
    } tit_state_e;
endpackage

// File: rtl/tit_regif.sv
`timescale 1ns/1ps
module tit_regif #(
    parameter int                 ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h50
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              ctl_wr,
    output logic              stat_wr,
    output logic              ctl_rd,
    output logic              stat_rd
);
    localparam logic [ADDR_W-1:0] STAT_A = BASE_ADDR + ADDR_W'(4);

    logic hit_ctl, hit_stat;

    always_comb begin
        hit_ctl  = (addr == BASE_ADDR);
        hit_stat = (addr == STAT_A);
        ctl_wr   = wr_en & hit_ctl;
        stat_wr  = wr_en & hit_stat;
        ctl_rd   = rd_en & hit_ctl;
        stat_rd  = rd_en & hit_stat;
    end
endmodule

// File: rtl/tit_core.sv
`timescale 1ns/1ps
module tit_core
    import tit_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic             en_in,
    input  logic             loop_in,
    input  logic [CNT_W-1:0] val_in,
    output tit_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rel_q,
    output logic             en_q,
    output logic             loop_q,
    output logic             expire
);
    tit_state_e       state_d;
    logic [CNT_W-1:0] cnt_d, rel_d;
    logic             en_d, loop_d;
    logic             at_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rel_q   <= '0;
            en_q    <= 1'b0;
            loop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rel_q   <= rel_d;
            en_q    <= en_d;
            loop_q  <= loop_d;
        end
    end

    // next state and datapath
    always_comb begin
        at_zero = (cnt_q == '0);
        state_d = state_q;
        cnt_d   = cnt_q;
        rel_d   = rel_q;
        en_d    = en_q;
        loop_d  = loop_q;
        if (ctl_wr) begin
            rel_d  = val_in;
            cnt_d  = val_in;
            en_d   = en_in;
            loop_d = loop_in;
            if (!en_in)       state_d = ST_IDLE;
            else if (loop_in) state_d = ST_RUN_LOOP;
            else              state_d = ST_RUN_ONCE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_RUN_ONCE: begin
                    if (tick) begin
                        if (at_zero) begin
                            state_d = ST_IDLE;
                            en_d    = 1'b0;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                ST_RUN_LOOP: begin
                    if (tick) begin
                        if (at_zero) cnt_d = rel_q;
                        else         cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        expire = tick && !ctl_wr && (state_q != ST_IDLE) && (cnt_q == '0);
    end
endmodule

// File: rtl/tit_irq.sv
`timescale 1ns/1ps
module tit_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic pend_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (expire) pend_q <= 1'b1;
        else if (clr)    pend_q <= 1'b0;
    end
endmodule

// File: rtl/tick_interval_timer.sv
`timescale 1ns/1ps
module tick_interval_timer
    import tit_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                CNT_W     = 29,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50,
    localparam int               DW        = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);
    localparam int EN_BIT   = DW - 1;
    localparam int LOOP_BIT = DW - 2;
    localparam int RSV_BIT  = DW - 3;

    logic             ctl_wr, stat_wr, ctl_rd, stat_rd;
    tit_state_e       state_q;
    logic [CNT_W-1:0] cnt_q, rel_q;
    logic             en_q, loop_q, expire, pend_q, clr;
    logic             unused_rsvd;

    assign unused_rsvd = wdata[RSV_BIT];
    assign clr         = stat_wr & wdata[LOOP_BIT];

    tit_regif #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regif (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .ctl_wr (ctl_wr),
        .stat_wr(stat_wr),
        .ctl_rd (ctl_rd),
        .stat_rd(stat_rd)
    );

    tit_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ctl_wr (ctl_wr),
        .en_in  (wdata[EN_BIT]),
        .loop_in(wdata[LOOP_BIT]),
        .val_in (wdata[CNT_W-1:0]),
        .state_q(state_q),
        .cnt_q  (cnt_q),
        .rel_q  (rel_q),
        .en_q   (en_q),
        .loop_q (loop_q),
        .expire (expire)
    );

    tit_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .expire(expire),
        .clr   (clr),
        .pend_q(pend_q)
    );

    always_comb begin
        if (ctl_rd)       rdata = {en_q, loop_q, 1'b0, rel_q};
        else if (stat_rd) rdata = {1'b0, pend_q, 1'b0, cnt_q};
        else              rdata = '0;
    end

    assign irq = pend_q;
endmodule

// File: rtl/tit_checker.sv
`timescale 1ns/1ps
module tit_checker
    import tit_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                CNT_W     = 29,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              clr_bit,
    input logic              irq,
    input tit_state_e        state_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  rel_q,
    input logic              expire,
    input logic              ctl_wr
);
    localparam logic [ADDR_W-1:0] STAT_A = BASE_ADDR + ADDR_W'(4);
    logic clr_req;
    assign clr_req = wr_en && (addr == STAT_A) && clr_bit;

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_req |=> irq);
    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && clr_req && !expire |=> !irq);
    // R8
    expire_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);
    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));
    // R5
    once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN_ONCE && expire |=> state_q == ST_IDLE);
    // R6
    loop_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN_LOOP && expire |=> state_q == ST_RUN_LOOP && cnt_q == rel_q);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && !ctl_wr |=> $stable(cnt_q));
    // R3
    notick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !ctl_wr |=> $stable(cnt_q));
endmodule

bind tick_interval_timer tit_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR)
) u_tit_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_en  (wr_en),
    .addr   (addr),
    .clr_bit(wdata[DW-2]),
    .irq    (irq),
    .state_q(state_q),
    .cnt_q  (cnt_q),
    .rel_q  (rel_q),
    .expire (expire),
    .ctl_wr (ctl_wr)
);

// File: tb/tb_tick_interval_timer.sv
`timescale 1ns/1ps
module tb_tick_interval_timer;
    localparam logic [7:0] CTL  = 8'h50;
    localparam logic [7:0] STAT = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tick_interval_timer #(.ADDR_W(8), .CNT_W(29), .BASE_ADDR(8'h50)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic [28:0] val;
        logic        loop;
        logic [7:0]  ticks;
        logic [28:0] exp_cnt;
        logic        exp_irq;
        logic        exp_en;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{29'd4,         1'b0, 8'd3,  29'd1,         1'b0, 1'b1},
        '{29'd4,         1'b0, 8'd5,  29'd0,         1'b1, 1'b0},
        '{29'd0,         1'b0, 8'd1,  29'd0,         1'b1, 1'b0},
        '{29'd0,         1'b0, 8'd0,  29'd0,         1'b0, 1'b1},
        '{29'd2,         1'b1, 8'd3,  29'd2,         1'b1, 1'b1},
        '{29'd2,         1'b1, 8'd5,  29'd0,         1'b1, 1'b1},
        '{29'd9,         1'b0, 8'd12, 29'd0,         1'b1, 1'b0},
        '{29'h1FFFFFFF,  1'b1, 8'd2,  29'h1FFFFFFD,  1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(CTL, v);  chk("R1 ctl", v, 32'd0);
        rd(STAT, v); chk("R1 stat", v, 32'd0);

        // table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < 8; k++) begin
            do_write(CTL, 32'd0, 1'b0);
            do_write(STAT, 32'h4000_0000, 1'b0);
            do_write(CTL, {1'b1, VECS[k].loop, 1'b0, VECS[k].val}, 1'b0);
            rd(CTL, v);
            chk("R2 ctl readback", v, {1'b1, VECS[k].loop, 1'b0, VECS[k].val});
            ticks(int'(VECS[k].ticks));
            idle(1);
            chk("R4 irq", {31'd0, irq}, {31'd0, VECS[k].exp_irq});
            rd(STAT, v);
            chk("R3 status", v, {1'b0, VECS[k].exp_irq, 1'b0, VECS[k].exp_cnt});
            rd(CTL, v);
            chk(VECS[k].loop ? "R6 enable" : "R5 enable", {31'd0, v[31]}, {31'd0, VECS[k].exp_en});
        end

        // R7 level hold and write-one-to-clear
        do_write(CTL, 32'd0, 1'b0);
        do_write(STAT, 32'h4000_0000, 1'b0);
        do_write(CTL, 32'h8000_0000, 1'b0);
        ticks(1);
        chk("R7 raised", {31'd0, irq}, 32'd1);
        do_write(STAT, 32'h8000_0000, 1'b0);
        idle(3);
        chk("R7 bit30 clear keeps irq", {31'd0, irq}, 32'd1);
        do_write(STAT, 32'h4000_0000, 1'b0);
        chk("R7 cleared", {31'd0, irq}, 32'd0);

        // R8 clear in expiry cycle
        do_write(CTL, 32'hC000_0000, 1'b0);
        ticks(1);
        do_write(STAT, 32'h4000_0000, 1'b1);
        chk("R8 pending kept", {31'd0, irq}, 32'd1);
        do_write(STAT, 32'h4000_0000, 1'b0);
        chk("R8 later clear", {31'd0, irq}, 32'd0);

        // R9 stop keeps pending, halts counting
        ticks(1);
        do_write(CTL, 32'd0, 1'b0);
        chk("R9 pending kept on stop", {31'd0, irq}, 32'd1);
        do_write(STAT, 32'h4000_0000, 1'b0);
        do_write(CTL, 32'h8000_0005, 1'b0);
        ticks(2);
        idle(5);
        rd(STAT, v); chk("R3 count holds without tick", v, 32'd3);
        do_write(CTL, 32'd0, 1'b0);
        rd(STAT, v); chk("R9 count zero", v, 32'd0);
        ticks(10);
        chk("R9 no expiry", {31'd0, irq}, 32'd0);
        rd(CTL, v); chk("R9 ctl", v, 32'd0);

        // R10 foreign addresses
        do_write(CTL, 32'h8000_0007, 1'b0);
        do_write(8'h58, 32'hFFFF_FFFF, 1'b0);
        do_write(8'h51, 32'hFFFF_FFFF, 1'b0);
        do_write(8'h00, 32'h4000_0000, 1'b0);
        rd(CTL, v);   chk("R10 ctl unchanged", v, 32'h8000_0007);
        rd(STAT, v);  chk("R10 stat unchanged", v, 32'd7);
        rd(8'h58, v); chk("R10 foreign read", v, 32'd0);

        // R11 write wins over tick
        do_write(CTL, 32'h8000_0010, 1'b1);
        rd(STAT, v); chk("R11 load not ticked", v, 32'h10);
        ticks(1);
        rd(STAT, v); chk("R11 next tick", v, 32'h0F);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule